// File: doc/BRIEF.md
# Prioritised Interrupt Accept Logic

This block holds the pending, in-service and trigger-mode state of a 256-entry interrupt vector space. Each vector has one bit in each of three vectors. Incoming requests carry a vector number and a level/edge flag. The block decides from a task priority and the highest vector in service whether the processor should be interrupted.

The processor acknowledges with a one-cycle strobe. One cycle later the block answers with either the winning vector, which moves from pending to in-service, or the low byte of the spurious register when the task priority holds the request back. An end-of-interrupt strobe retires the highest vector in service. The task priority is written as a 4-bit class and is kept in the upper nibble of an 8-bit priority. The spurious register carries the software enable in bit 8.

Top module: `prio_irq_accept`

## Requirements
- R1: A request with `req_valid` high sets pending bit `req_vec`. It sets trigger bit `req_vec` when `req_level` is 1 and clears it when `req_level` is 0.
- R2: `prio_q` equals the task priority when the class (bits 7:4) of the task priority is at least the class of the highest in-service vector, or when no vector is in service. Otherwise it equals that in-service class with low nibble 0.
- R3: `irq` is high only when enable bit 8 of the spurious register is set, some vector is pending, and either `prio_q` is zero or the class of the highest pending vector is greater than the class of `prio_q`.
- R4: An acknowledge that is granted clears the pending bit of the highest pending vector, sets its in-service bit, and returns that vector on `ack_vec` with `ack_valid` high one cycle after `ack_req`.
- R5: An acknowledge is refused when nothing is pending, or when the task priority is nonzero and the highest pending vector is not numerically above it. A refused acknowledge returns bits 7:0 of the spurious register and changes no pending or in-service bit.
- R6: `eoi` clears the highest-numbered set in-service bit. With no bit in service it has no effect.
- R7: The spurious register resets to 0x0FF, so the block starts disabled. A write keeps bits 8:0 of `spur_wdata`. While bit 8 is clear, `irq` stays low.
- R8: A task priority write stores `tpr_wdata` in bits 7:4 of the priority with zero low bits. `tpr_rd` returns those four bits.
- R9: All state changes one cycle after the strobe that causes it. When a request and a granted acknowledge hit the same vector in one cycle, the pending bit stays set and the in-service bit is also set.
- R10: After reset the pending, in-service and trigger vectors are all zero, the task priority is zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Interrupt request strobe |
| req_vec | input | 8 | Requested vector |
| req_level | input | 1 | 1 = level-triggered, 0 = edge |
| ack_req | input | 1 | Acknowledge strobe from processor |
| ack_valid | output | 1 | Acknowledge answer valid |
| ack_vec | output | 8 | Granted vector or spurious vector |
| eoi | input | 1 | End-of-interrupt strobe |
| tpr_wr | input | 1 | Task priority write enable |
| tpr_wdata | input | 4 | Task priority class to write |
| tpr_rd | output | 4 | Task priority class |
| spur_wr | input | 1 | Spurious register write enable |
| spur_wdata | input | 32 | Spurious register write data |
| spur_q | output | 9 | Spurious register contents |
| irq | output | 1 | Interrupt to the processor |
| prio_q | output | 8 | Processor priority |
| pend_q | output | 256 | Pending vector bits |
| insvc_q | output | 256 | In-service vector bits |
| trig_q | output | 256 | Trigger-mode bits |

## Verification
The bench checks that `irq` stays low for a pending vector in the same class as the vector in service. A design that compared whole vectors instead of classes would raise it there. It acknowledges under a blocking task priority and expects the spurious byte, with the pending and in-service bits untouched. A design that granted anyway would move the vector into service. It retires two nested in-service vectors in order and then sends one extra end-of-interrupt, which catches retiring the lowest vector instead of the highest, or disturbing state when nothing is in service. It also drives a request and an acknowledge of the same vector in one cycle, where a design that let the acknowledge win would lose the new request.

// File: rtl/prio_irq_accept.sv
module prio_irq_accept #(
  parameter int NVEC = 256,
  parameter int SPW  = 9,
  localparam int VW  = $clog2(NVEC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [VW-1:0]   req_vec,
  input  logic            req_level,
  input  logic            ack_req,
  output logic            ack_valid,
  output logic [VW-1:0]   ack_vec,
  input  logic            eoi,
  input  logic            tpr_wr,
  input  logic [3:0]      tpr_wdata,
  output logic [3:0]      tpr_rd,
  input  logic            spur_wr,
  input  logic [31:0]     spur_wdata,
  output logic [SPW-1:0]  spur_q,
  output logic            irq,
  output logic [VW-1:0]   prio_q,
  output logic [NVEC-1:0] pend_q,
  output logic [NVEC-1:0] insvc_q,
  output logic [NVEC-1:0] trig_q
);
  function automatic logic [VW:0] top_bit(input logic [NVEC-1:0] v);
    logic [VW:0] r;
    r = '0;
    for (int i = 0; i < NVEC; i++)
      if (v[i]) r = {1'b1, VW'(i)};
    return r;
  endfunction

  logic [VW-1:0] tpr;
  logic [VW:0]   pend_top, svc_top;
  logic          grant;
  logic [NVEC-1:0] set_m, ack_m, eoi_m;

  assign pend_top = top_bit(pend_q);
  assign svc_top  = top_bit(insvc_q);
  assign tpr_rd   = tpr[VW-1:VW-4];

  assign prio_q = (!svc_top[VW] || tpr[VW-1:VW-4] >= svc_top[VW-1:VW-4])
                  ? tpr : {svc_top[VW-1:VW-4], {(VW-4){1'b0}}};

  assign irq = spur_q[SPW-1] && pend_top[VW] &&
               (prio_q == '0 || pend_top[VW-1:VW-4] > prio_q[VW-1:VW-4]);

  assign grant = pend_top[VW] && !(tpr != '0 && pend_top[VW-1:0] <= tpr);

  assign set_m = req_valid ? (NVEC'(1) << req_vec) : '0;
  assign ack_m = (ack_req && grant) ? (NVEC'(1) << pend_top[VW-1:0]) : '0;
  assign eoi_m = (eoi && svc_top[VW]) ? (NVEC'(1) << svc_top[VW-1:0]) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q    <= '0;
      insvc_q   <= '0;
      trig_q    <= '0;
      tpr       <= '0;
      spur_q    <= SPW'(8'hFF);
      ack_valid <= 1'b0;
      ack_vec   <= '0;
    end else begin
      pend_q    <= (pend_q & ~ack_m) | set_m;
      insvc_q   <= (insvc_q & ~eoi_m) | ack_m;
      if (req_valid) trig_q[req_vec] <= req_level;
      if (tpr_wr) tpr <= {tpr_wdata, {(VW-4){1'b0}}};
      if (spur_wr) spur_q <= spur_wdata[SPW-1:0];
      ack_valid <= ack_req;
      if (ack_req) ack_vec <= grant ? pend_top[VW-1:0] : spur_q[VW-1:0];
    end
  end

  p_set_pending_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> pend_q[$past(req_vec)]);
  p_trig_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> trig_q[$past(req_vec)] == $past(req_level));
  p_enable_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !spur_q[SPW-1] |-> !irq);
  p_ack_answer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |=> ack_valid);
  p_refuse_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !grant && !eoi && !req_valid) |=> $stable(insvc_q) && $stable(pend_q));
  p_eoi_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack_req && insvc_q != '0) |=>
      $countones(insvc_q) == $countones($past(insvc_q)) - 1);
  p_prio_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
    prio_q[VW-1:VW-4] >= tpr_rd);
endmodule

// File: tb/tb_prio_irq_accept.sv
module tb_prio_irq_accept;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_level = 0, ack_req = 0, eoi = 0, tpr_wr = 0, spur_wr = 0;
  logic [7:0] req_vec = 0;
  logic [3:0] tpr_wdata = 0;
  logic [31:0] spur_wdata = 0;
  logic ack_valid, irq;
  logic [7:0] ack_vec, prio_q;
  logic [3:0] tpr_rd;
  logic [8:0] spur_q;
  logic [255:0] pend_q, insvc_q, trig_q;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  prio_irq_accept dut (.*);

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic request(input logic [7:0] v, input logic lvl);
    req_valid = 1; req_vec = v; req_level = lvl; tick(); req_valid = 0;
  endtask

  task automatic acknowledge(); ack_req = 1; tick(); ack_req = 0; endtask
  task automatic do_eoi(); eoi = 1; tick(); eoi = 0; endtask
  task automatic set_tpr(input logic [3:0] t); tpr_wr = 1; tpr_wdata = t; tick(); tpr_wr = 0; endtask
  task automatic set_spur(input logic [31:0] d); spur_wr = 1; spur_wdata = d; tick(); spur_wr = 0; endtask

  task automatic t_reset();
    chk("R10 pend", 32'($countones(pend_q)), 0);
    chk("R10 insvc", 32'($countones(insvc_q)), 0);
    chk("R10 trig", 32'($countones(trig_q)), 0);
    chk("R10 tpr", 32'(tpr_rd), 0);
    chk("R10 irq", 32'(irq), 0);
    chk("R7 spur reset", 32'(spur_q), 32'h0FF);
    acknowledge();
    chk("R5 empty ack valid", 32'(ack_valid), 1);
    chk("R5 empty ack spurious", 32'(ack_vec), 32'hFF);
  endtask

  task automatic t_set();
    request(8'h45, 1);
    chk("R1 pend set", 32'(pend_q[8'h45]), 1);
    chk("R1 level trig", 32'(trig_q[8'h45]), 1);
    chk("R7 disabled irq", 32'(irq), 0);
    request(8'h45, 0);
    chk("R1 edge trig", 32'(trig_q[8'h45]), 0);
    set_spur(32'h0000_013F);
    chk("R7 spur write", 32'(spur_q), 32'h13F);
    chk("R3 irq zero prio", 32'(irq), 1);
  endtask

  task automatic t_ack();
    acknowledge();
    chk("R4 ack vec", 32'(ack_vec), 32'h45);
    chk("R4 pend cleared", 32'(pend_q[8'h45]), 0);
    chk("R4 insvc set", 32'(insvc_q[8'h45]), 1);
    chk("R2 prio from isr", 32'(prio_q), 32'h40);
    request(8'h42, 0);
    chk("R3 same class blocked", 32'(irq), 0);
    request(8'h61, 0);
    chk("R3 higher class", 32'(irq), 1);
  endtask

  task automatic t_tpr();
    set_tpr(4'h7);
    chk("R8 tpr read", 32'(tpr_rd), 7);
    chk("R2 prio from tpr", 32'(prio_q), 32'h70);
    chk("R3 tpr blocks irq", 32'(irq), 0);
    acknowledge();
    chk("R5 spurious vec", 32'(ack_vec), 32'h3F);
    chk("R5 pend kept", 32'(pend_q[8'h61]), 1);
    chk("R5 insvc kept", 32'($countones(insvc_q)), 1);
    set_tpr(4'h5);
    chk("R3 tpr lowered", 32'(irq), 1);
    acknowledge();
    chk("R4 second grant", 32'(ack_vec), 32'h61);
    chk("R2 isr class wins", 32'(prio_q), 32'h60);
  endtask

  task automatic t_eoi();
    do_eoi();
    chk("R6 highest retired", 32'(insvc_q[8'h61]), 0);
    chk("R6 lower kept", 32'(insvc_q[8'h45]), 1);
    do_eoi();
    chk("R6 second retired", 32'($countones(insvc_q)), 0);
    do_eoi();
    chk("R6 empty eoi", 32'($countones(insvc_q)), 0);
    chk("R6 pend untouched", 32'($countones(pend_q)), 1);
  endtask

  task automatic t_collide();
    set_tpr(4'h0);
    request(8'h80, 0);
    req_valid = 1; req_vec = 8'h80; req_level = 1; ack_req = 1;
    tick();
    req_valid = 0; ack_req = 0;
    chk("R9 ack vec", 32'(ack_vec), 32'h80);
    chk("R9 set wins pend", 32'(pend_q[8'h80]), 1);
    chk("R9 insvc set", 32'(insvc_q[8'h80]), 1);
    set_spur(32'hFFFF_FE2A);
    chk("R7 keep 9 bits", 32'(spur_q), 32'h02A);
    chk("R7 disabled no irq", 32'(irq), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_set();
    t_ack();
    t_tpr();
    t_eoi();
    t_collide();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule